// File: doc/BRIEF.md
# Indirect Configuration RAM Access Port

This block gives a host a way into a per-channel configuration RAM that is not mapped onto the register bus directly. The host sees two registers on a simple synchronous bus. The first is a command/status register. Writing it names a RAM word, picks a direction and picks an arbitration delay. Reading it returns those fields and a busy flag. The second is a 16-bit data register that carries the word going into the RAM or the word coming back out of it.

The RAM is single-ported and shared with a DMA engine. The port must wait a programmable number of cycles before the RAM is granted to it. While a command is in flight the busy flag stays set. During that time the block ignores further commands and further writes to the data register. The host therefore polls busy before it uses read data or issues the next command.

Top module: `icr_port`

## Requirements
- R1: After reset, the command/status register (offset 0x770) reads 0x0000 (busy clear) and the data register (offset 0x774) reads 0x0000.
- R2: A bus write to 0x770 while idle starts a transaction. Bits [5:0] give the RAM word, bit 14 gives the direction (1 = read, 0 = write) and bits [13:12] give the delay code. After completion, 0x770 reads back those three fields with bit 15 clear.
- R3: An indirect write holds busy (bit 15 of 0x770) high for exactly D+1 cycles after the command write. It stores the data register value into the addressed RAM word.
- R4: An indirect read holds busy high for exactly D+2 cycles after the command write. After that, the data register holds the addressed RAM word.
- R5: The arbitration delay is D = 2 + code, saturating at 4. Codes 0, 1, 2 and 3 give D = 2, 3, 4 and 4.
- R6: A write to 0x770 while busy is ignored. The fields read back, the word accessed and the busy length are those of the first command, and no second transaction follows.
- R7: A write to 0x774 while busy is ignored. An indirect write stores the value the data register held when the command was issued.
- R8: While idle, the data register at 0x774 reads back what was last written to it. Writes to any other address have no effect. bus_rdata is zero when bus_rd is low or the address matches neither register.
- R9: RAM words keep their contents across reads and across writes to other words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 16 | Register write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_rdata | output | 16 | Register read data |

## Verification
The bench counts the exact number of cycles for which busy stays set, once for each delay code and each direction. A grant that comes a cycle early or late, or a delay code that fails to saturate, shows up as a wrong busy length. A command is fired into the middle of a read, and the bench checks that the original address and fields survive and that no second access slips through afterwards. A design that re-latched the command would return the wrong word or stay busy too long. A data write issued during a write transaction must not reach the RAM. A design without that guard would store the late value. Words at the address extremes are overwritten and reread to catch aliasing or corruption of neighbouring words.

// File: rtl/icr_pkg.sv
package icr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARB,
    ST_ACC,
    ST_CAP
  } seq_state_e;

  // Number of arbitration cycles selected by a delay code.
  function automatic int arb_cycles(input int code, input int lo, input int hi);
    int s;
    s = lo + code;
    return (s > hi) ? hi : s;
  endfunction

endpackage

// File: rtl/icr_ram.sv
module icr_ram #(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        mem[addr] <= wdata;
      end else begin
        rdata_q <= mem[addr];
      end
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/icr_seq.sv
module icr_seq
  import icr_pkg::*;
#(
  parameter int AW      = 6,
  parameter int DLY_W   = 2,
  parameter int ARB_MIN = 2,
  parameter int ARB_MAX = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [AW-1:0]    cmd_addr,
  input  logic             cmd_rd,
  input  logic [DLY_W-1:0] cmd_dly,
  output logic             busy,
  output logic [AW-1:0]    cur_addr,
  output logic             cur_rd,
  output logic [DLY_W-1:0] cur_dly,
  output logic             ram_en,
  output logic             ram_we,
  output logic [AW-1:0]    ram_addr,
  output logic             load_data
);
  localparam int CNT_W = $clog2(ARB_MAX + 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [AW-1:0]    addr_q;
  logic             rd_q;
  logic [DLY_W-1:0] dly_q;
  logic             cap_en;
  logic [CNT_W-1:0] dly_cyc;

  assign dly_cyc = CNT_W'(arb_cycles(int'(cmd_dly), ARB_MIN, ARB_MAX));
  assign cap_en  = (state_q == ST_IDLE) && cmd_wr;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_wr) begin
          state_d = ST_ARB;
          cnt_d   = dly_cyc - CNT_W'(1);
        end
      end
      ST_ARB: begin
        if (cnt_q == '0) begin
          state_d = ST_ACC;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_ACC:  state_d = rd_q ? ST_CAP : ST_IDLE;
      ST_CAP:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // Command field registers, enabled on acceptance only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rd_q   <= 1'b0;
      dly_q  <= '0;
    end else if (cap_en) begin
      addr_q <= cmd_addr;
      rd_q   <= cmd_rd;
      dly_q  <= cmd_dly;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign cur_addr  = addr_q;
  assign cur_rd    = rd_q;
  assign cur_dly   = dly_q;
  assign ram_en    = (state_q == ST_ACC);
  assign ram_we    = ram_en && !rd_q;
  assign ram_addr  = addr_q;
  assign load_data = (state_q == ST_CAP);

  // Checker: length of the arbitration window seen so far
  logic [CNT_W:0] arb_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arb_len_q <= '0;
    end else if (state_q == ST_ARB) begin
      arb_len_q <= arb_len_q + 1'b1;
    end else if (state_q == ST_IDLE) begin
      arb_len_q <= '0;
    end
  end

  assert_arb_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACC) |->
      (int'(arb_len_q) == arb_cycles(int'(dly_q), ARB_MIN, ARB_MAX)));

  assert_grant_after_arb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> ($past(state_q) == ST_ARB));

  assert_cmd_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> ($stable(addr_q) && $stable(rd_q) && $stable(dly_q)));

  assert_read_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_data |-> ($past(ram_en) && !$past(ram_we)));
endmodule

// File: rtl/icr_regbank.sv
module icr_regbank #(
  parameter int          BUS_AW   = 12,
  parameter int          DW       = 16,
  parameter int          AW       = 6,
  parameter int          DLY_W    = 2,
  parameter int          DLY_LSB  = 12,
  parameter int          DIR_BIT  = 14,
  parameter int          BUSY_BIT = 15,
  parameter logic [11:0] CTRL_OFS = 12'h770,
  parameter logic [11:0] DATA_OFS = 12'h774
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DW-1:0]     bus_rdata,
  input  logic              busy,
  input  logic [AW-1:0]     cur_addr,
  input  logic              cur_rd,
  input  logic [DLY_W-1:0]  cur_dly,
  input  logic              load_data,
  input  logic [DW-1:0]     ram_rdata,
  output logic [DW-1:0]     data_out,
  output logic              cmd_wr,
  output logic [AW-1:0]     cmd_addr,
  output logic              cmd_rd,
  output logic [DLY_W-1:0]  cmd_dly
);
  logic          hit_ctrl, hit_data;
  logic          host_dwr;
  logic          data_en;
  logic [DW-1:0] data_q, data_d;
  logic [DW-1:0] ctrl_view;

  assign hit_ctrl = (bus_addr == BUS_AW'(CTRL_OFS));
  assign hit_data = (bus_addr == BUS_AW'(DATA_OFS));

  assign cmd_wr   = bus_wr && hit_ctrl;
  assign cmd_addr = bus_wdata[AW-1:0];
  assign cmd_rd   = bus_wdata[DIR_BIT];
  assign cmd_dly  = bus_wdata[DLY_LSB +: DLY_W];

  assign host_dwr = bus_wr && hit_data && !busy;
  assign data_en  = load_data || host_dwr;

  // Data register next value
  always_comb begin
    data_d = data_q;
    if (load_data) begin
      data_d = ram_rdata;
    end else if (host_dwr) begin
      data_d = bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  // Status view of the command register
  always_comb begin
    ctrl_view                      = '0;
    ctrl_view[AW-1:0]              = cur_addr;
    ctrl_view[DLY_LSB +: DLY_W]    = cur_dly;
    ctrl_view[DIR_BIT]             = cur_rd;
    ctrl_view[BUSY_BIT]            = busy;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (hit_ctrl) begin
        bus_rdata = ctrl_view;
      end else if (hit_data) begin
        bus_rdata = data_q;
      end
    end
  end

  assign data_out = data_q;

  assert_busy_blocks_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr && hit_data && !load_data) |=> $stable(data_q));

  assert_data_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_q) |-> $past(load_data || (bus_wr && hit_data && !busy)));
endmodule

// File: rtl/icr_port.sv
module icr_port #(
  parameter int          BUS_AW   = 12,
  parameter int          DW       = 16,
  parameter int          RAM_AW   = 6,
  parameter int          DLY_W    = 2,
  parameter int          DLY_LSB  = 12,
  parameter int          DIR_BIT  = 14,
  parameter int          BUSY_BIT = 15,
  parameter int          ARB_MIN  = 2,
  parameter int          ARB_MAX  = 4,
  parameter logic [11:0] CTRL_OFS = 12'h770,
  parameter logic [11:0] DATA_OFS = 12'h774
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DW-1:0]     bus_rdata
);
  logic [1:0]        rst_sync_q;
  logic              rst_i_n;
  logic              busy;
  logic [RAM_AW-1:0] cur_addr, cmd_addr, ram_addr;
  logic              cur_rd, cmd_rd, cmd_wr;
  logic [DLY_W-1:0]  cur_dly, cmd_dly;
  logic              load_data, ram_en, ram_we;
  logic [DW-1:0]     ram_rdata, data_reg;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_i_n = rst_sync_q[1];

  icr_regbank #(
    .BUS_AW(BUS_AW), .DW(DW), .AW(RAM_AW), .DLY_W(DLY_W), .DLY_LSB(DLY_LSB),
    .DIR_BIT(DIR_BIT), .BUSY_BIT(BUSY_BIT), .CTRL_OFS(CTRL_OFS), .DATA_OFS(DATA_OFS)
  ) u_regs (
    .clk(clk), .rst_n(rst_i_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata),
    .busy(busy), .cur_addr(cur_addr), .cur_rd(cur_rd), .cur_dly(cur_dly),
    .load_data(load_data), .ram_rdata(ram_rdata), .data_out(data_reg),
    .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_rd(cmd_rd), .cmd_dly(cmd_dly)
  );

  icr_seq #(
    .AW(RAM_AW), .DLY_W(DLY_W), .ARB_MIN(ARB_MIN), .ARB_MAX(ARB_MAX)
  ) u_seq (
    .clk(clk), .rst_n(rst_i_n),
    .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_rd(cmd_rd), .cmd_dly(cmd_dly),
    .busy(busy), .cur_addr(cur_addr), .cur_rd(cur_rd), .cur_dly(cur_dly),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .load_data(load_data)
  );

  icr_ram #(.DW(DW), .AW(RAM_AW)) u_ram (
    .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr),
    .wdata(data_reg), .rdata(ram_rdata)
  );

  assert_write_from_idle_data_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy && !load_data) |=> $stable(data_reg));
endmodule

// File: tb/icr_port_tb_top.sv
`timescale 1ns/1ps
module icr_port_tb_top;
  localparam logic [11:0] CTRL = 12'h770;
  localparam logic [11:0] DATA = 12'h774;

  typedef struct {
    logic [15:0] val;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic [15:0] bus_wdata;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_rdata;

  int          n_chk = 0;
  int          n_fail = 0;
  exp_t        exp_q[$];
  logic [15:0] shadow [64];

  always #2.5 clk = ~clk;

  icr_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: every data-register read is compared against the scoreboard
  always @(negedge clk) begin
    #1;
    if (bus_rd && bus_addr == DATA) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R8 actual=%h expected=<no item queued>", bus_rdata);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.req, bus_rdata, e.val);
      end
    end
  end

  function automatic logic [15:0] mk(input int a, input bit rd, input int code);
    return 16'(a & 63) | (16'(rd) << 14) | (16'(code & 3) << 12);
  endfunction

  function automatic int dcyc(input int code);
    return (2 + code > 4) ? 4 : 2 + code;
  endfunction

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic expect_data(input logic [15:0] v, input string req);
    logic [15:0] dummy;
    exp_t e;
    e.val = v; e.req = req;
    exp_q.push_back(e);
    rd(DATA, dummy);
  endtask

  task automatic poll(output int n);
    logic [15:0] v;
    n = 0;
    for (int g = 0; g < 50; g++) begin
      rd(CTRL, v);
      if (!v[15]) break;
      n++;
    end
  endtask

  task automatic do_write(input int a, input logic [15:0] v, input int code);
    int n;
    logic [15:0] c;
    wr(DATA, v);
    wr(CTRL, mk(a, 1'b0, code));
    poll(n);
    check("R3 write busy length", 16'(n), 16'(dcyc(code) + 1));
    rd(CTRL, c);
    check("R2 ctrl readback after write", c, mk(a, 1'b0, code));
    shadow[a] = v;
  endtask

  task automatic do_read(input int a, input int code);
    int n;
    logic [15:0] c;
    wr(CTRL, mk(a, 1'b1, code));
    poll(n);
    check("R4 read busy length", 16'(n), 16'(dcyc(code) + 2));
    rd(CTRL, c);
    check("R2 ctrl readback after read", c, mk(a, 1'b1, code));
    expect_data(shadow[a], "R4 read data");
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int n;
    bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(CTRL, v);
    check("R1 ctrl after reset", v, 16'h0000);
    expect_data(16'h0000, "R1 data after reset");

    // R8 data register read/write while idle, rdata zero without strobe
    wr(DATA, 16'hA5A5);
    expect_data(16'hA5A5, "R8 data readback");
    bus_addr = DATA; #1;
    check("R8 rdata with no read strobe", bus_rdata, 16'h0000);
    @(negedge clk);

    // R3/R5: writes with every delay code, extremes of the address range
    do_write(0,  16'h1234, 0);
    do_write(63, 16'hFEDC, 1);
    do_write(5,  16'h0F0F, 2);
    do_write(17, 16'hC3C3, 3);
    do_write(9,  16'h9999, 0);

    // R4/R5: reads with every delay code
    do_read(0,  3);
    do_read(63, 2);
    do_read(5,  1);
    do_read(17, 0);

    // R9: overwrite one word, neighbours and rereads unchanged
    do_write(63, 16'h0001, 1);
    do_read(0, 0);
    do_read(63, 0);
    do_read(63, 1);
    do_read(17, 2);

    // R6: command while busy is ignored
    wr(CTRL, mk(5, 1'b1, 3));
    wr(CTRL, mk(9, 1'b0, 0));
    poll(n);
    check("R6 busy length unchanged", 16'(n + 1), 16'(dcyc(3) + 2));
    rd(CTRL, v);
    check("R6 fields of first command kept", v, mk(5, 1'b1, 3));
    expect_data(shadow[5], "R6 first command word read");
    for (int i = 0; i < 3; i++) begin
      rd(CTRL, v);
      check("R6 no second transaction", {15'd0, v[15]}, 16'h0000);
    end
    do_read(9, 0);

    // R7: data write while busy is ignored
    wr(DATA, 16'h1111);
    wr(CTRL, mk(20, 1'b0, 2));
    wr(DATA, 16'h2222);
    expect_data(16'h1111, "R7 data held during busy");
    poll(n);
    check("R7 busy length", 16'(n + 2), 16'(dcyc(2) + 1));
    shadow[20] = 16'h1111;
    do_read(20, 0);

    // R8: other addresses have no effect and read zero
    wr(12'h778, 16'hBEEF);
    rd(12'h778, v);
    check("R8 unmapped reads zero", v, 16'h0000);
    expect_data(16'h1111, "R8 data untouched by unmapped write");
    rd(CTRL, v);
    check("R8 ctrl untouched by unmapped write", v, mk(20, 1'b1, 0));

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule